// File: doc/BRIEF.md
# Switching-Period Qualified Enable Counter

This block watches a one-cycle strobe that arrives once per power-conversion cycle. It measures the number of clock ticks between successive strobes and from that decides whether the secondary-side circuitry should stay enabled. The decision is driven out as a registered control for an open-drain pull-down. When the control is high the pull-down conducts and the secondary circuitry is disabled. When it is low the pin floats, which means the circuitry is enabled.

The on and off rules are deliberately different. Disabling needs an unbroken run of slow periods: every period in the run must be longer than a long threshold. Re-enabling needs a total number of fast periods, each shorter than a short threshold. Those fast periods do not have to be consecutive, and periods between the two thresholds neither add to that total nor clear it. The period timer stops at a ceiling, so an arbitrarily long silence still reads as one slow period. A status flag shows whether the first strobe has arrived and period timing is active.

All thresholds are parameters, and so are both run lengths. With a 10 MHz clock the defaults are 1770 and 570 ticks, with runs of 63 and 32.

Top module: `swq_enable_qual`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pd_on_o` = 0 (enabled) and `armed_o` = 0.
- R2: The first `pcd_i` pulse after reset sets `armed_o` = 1 on the next clock and is not counted as a period. `pd_on_o` stays 0 while `armed_o` = 0.
- R3: A period is the number of clock cycles between two `pcd_i` pulses. Pulses one cycle apart give a period of 1. A period is slow when it is greater than `LONG_TICKS` and fast when it is less than `SHORT_TICKS`.
- R4: In the enabled state, `SLOW_RUN` consecutive slow periods set `pd_on_o` to 1 on the clock after the pulse that ends the last one. `pd_on_o` changes only on the clock after a `pcd_i` pulse.
- R5: In the enabled state, any period of `LONG_TICKS` or less restarts the consecutive slow run from zero.
- R6: In the disabled state, `FAST_TOTAL` fast periods set `pd_on_o` back to 0 on the clock after the pulse that ends the last one.
- R7: In the disabled state, periods of `SHORT_TICKS` or more neither add to the fast total nor clear it.
- R8: After re-enabling, a full fresh run of `SLOW_RUN` slow periods is needed to disable again.
- R9: The period timer saturates instead of wrapping, so any silence longer than `LONG_TICKS` counts as exactly one slow period.
- R10: A period of exactly `LONG_TICKS` is not slow. A period of exactly `SHORT_TICKS` is not fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pcd_i | input | 1 | One-cycle strobe marking the end of a switching period |
| pd_on_o | output | 1 | 1 = pull-down on (secondary disabled), 0 = released (enabled) |
| armed_o | output | 1 | 1 once the first strobe has started period timing |

## Verification
Two things can fall in the same cycle: the timer reaching its ceiling, and a strobe closing the period. The bench provokes this with gaps of exactly the long threshold, one tick more, and far more, and the result must match a reference that keeps an unbounded integer tick count. A second coincidence is the strobe that completes a run. That single edge must flip the state, restart the finished counter and leave the other counter empty. The bench judges this by the exact number of further periods needed for the next flip. Outputs are compared with the reference model on every clock.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic {
    ST_ENABLED  = 1'b0,
    ST_DISABLED = 1'b1
  } swq_state_t;
endpackage

// File: rtl/swq_period_timer.sv
module swq_period_timer #(
  parameter int LONG_TICKS  = 1770,
  parameter int SHORT_TICKS = 570,
  localparam int CAP = LONG_TICKS + 1,
  localparam int TW  = $clog2(CAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pcd,
  output logic is_slow,
  output logic is_fast
);
  logic [TW-1:0] tmr;

  // Tick count since last strobe; held at CAP once past the long limit.
  always_ff @(posedge clk) begin
    if (rst)                  tmr <= '0;
    else if (pcd)             tmr <= TW'(1);
    else if (tmr != TW'(CAP)) tmr <= tmr + TW'(1);
  end

  assign is_slow = (tmr == TW'(CAP));
  assign is_fast = (tmr < TW'(SHORT_TICKS));

  p_tmr_bound_r9: assert property (@(posedge clk) disable iff (rst)
    tmr <= TW'(CAP));
  p_tmr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tmr == TW'(CAP) && !pcd) |=> tmr == TW'(CAP));
  p_tmr_restart_r3: assert property (@(posedge clk) disable iff (rst)
    pcd |=> tmr == TW'(1));
endmodule

// File: rtl/swq_run_counter.sv
module swq_run_counter #(
  parameter int LIMIT  = 63,
  parameter bit CONSEC = 1'b1,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic miss,
  output logic hit
);
  logic [CW-1:0] cnt;
  logic          clr_on_miss;

  generate
    if (CONSEC) begin : g_consec
      assign clr_on_miss = miss;
    end else begin : g_cumul
      assign clr_on_miss = miss & 1'b0;
    end
  endgenerate

  assign hit = inc && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (inc)          cnt <= hit ? '0 : cnt + CW'(1);
    else if (clr_on_miss)  cnt <= '0;
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));
  p_hit_wraps_r8: assert property (@(posedge clk) disable iff (rst)
    hit |=> cnt == '0);
endmodule

// File: rtl/swq_enable_qual.sv
module swq_enable_qual
  import swq_pkg::*;
#(
  parameter int LONG_TICKS  = 1770,
  parameter int SHORT_TICKS = 570,
  parameter int SLOW_RUN    = 63,
  parameter int FAST_TOTAL  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic pcd_i,
  output logic pd_on_o,
  output logic armed_o
);
  swq_state_t state;
  logic       armed;
  logic       is_slow, is_fast, counted;
  logic       slow_hit, fast_hit;
  logic       in_en, in_dis;

  swq_period_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .pcd(pcd_i), .is_slow(is_slow), .is_fast(is_fast)
  );

  assign counted = pcd_i && armed;
  assign in_en   = (state == ST_ENABLED);
  assign in_dis  = (state == ST_DISABLED);

  swq_run_counter #(.LIMIT(SLOW_RUN), .CONSEC(1'b1)) u_slow (
    .clk(clk), .rst(rst), .clr(fast_hit),
    .inc(counted && in_en && is_slow),
    .miss(counted && in_en && !is_slow),
    .hit(slow_hit)
  );

  swq_run_counter #(.LIMIT(FAST_TOTAL), .CONSEC(1'b0)) u_fast (
    .clk(clk), .rst(rst), .clr(slow_hit),
    .inc(counted && in_dis && is_fast),
    .miss(1'b0),
    .hit(fast_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ENABLED;
      armed <= 1'b0;
    end else begin
      if (pcd_i)         armed <= 1'b1;
      if (slow_hit)      state <= ST_DISABLED;
      else if (fast_hit) state <= ST_ENABLED;
    end
  end

  assign pd_on_o = (state == ST_DISABLED);
  assign armed_o = armed;

  p_no_pd_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
    !armed_o |-> !pd_on_o);
  p_hold_no_pcd_r4: assert property (@(posedge clk) disable iff (rst)
    !pcd_i |=> $stable(pd_on_o));
  p_hits_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(slow_hit && fast_hit));
endmodule

// File: tb/tb_swq_enable_qual.sv
module tb_swq_enable_qual;
  localparam int LT = 40;
  localparam int ST = 12;
  localparam int SR = 5;
  localparam int FT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pcd = 1'b0;
  logic pd_on, armed;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  swq_enable_qual #(.LONG_TICKS(LT), .SHORT_TICKS(ST), .SLOW_RUN(SR), .FAST_TOTAL(FT)) dut (
    .clk(clk), .rst(rst), .pcd_i(pcd), .pd_on_o(pd_on), .armed_o(armed)
  );

  // Behavioural reference model
  int m_ticks = 0, m_armed = 0, m_off = 0, m_slow = 0, m_fast = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_ticks = 0; m_armed = 0; m_off = 0; m_slow = 0; m_fast = 0;
    end else if (pcd) begin
      if (m_armed != 0) begin
        if (m_off == 0) begin
          if (m_ticks > LT) m_slow++; else m_slow = 0;
          if (m_slow == SR) begin m_off = 1; m_slow = 0; m_fast = 0; end
        end else begin
          if (m_ticks < ST) m_fast++;
          if (m_fast == FT) begin m_off = 0; m_fast = 0; m_slow = 0; end
        end
      end
      m_armed = 1;
      m_ticks = 1;
    end else if (m_ticks < 1000000) begin
      m_ticks++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R4 state, R2 armed flag)
  always @(negedge clk) begin
    chk("R4 pd_on vs model", pd_on, logic'(m_off != 0));
    chk("R2 armed vs model", armed, logic'(m_armed != 0));
  end

  // Period of n cycles, ending with a strobe
  task automatic gap(input int n);
    for (int i = 0; i < n - 1; i++) @(negedge clk);
    pcd = 1'b1;
    @(negedge clk);
    pcd = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pd_on in reset", pd_on, 1'b0);
    chk("R1 armed in reset", armed, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pd_on after release", pd_on, 1'b0);
    chk("R1 armed after release", armed, 1'b0);

    gap(3);
    chk("R2 armed after first strobe", armed, 1'b1);
    chk("R2 first strobe not counted", pd_on, 1'b0);

    for (int i = 0; i < SR - 1; i++) gap(LT + 10);
    gap(LT);
    chk("R10 period of exactly LONG not slow", pd_on, 1'b0);
    for (int i = 0; i < SR - 1; i++) gap(LT + 1);
    chk("R5 run restarted after short period", pd_on, 1'b0);
    gap(LT + 1);
    chk("R4 disabled after full slow run", pd_on, 1'b1);
    chk("R3 boundary LONG+1 is slow", pd_on, 1'b1);

    gap(500);
    gap(1);
    gap(5);
    gap(ST - 1);
    gap(ST);
    chk("R10 period of exactly SHORT not fast", pd_on, 1'b1);
    gap(30);
    chk("R7 mid periods leave total", pd_on, 1'b1);
    gap(4);
    chk("R6 re-enabled after fast total", pd_on, 1'b0);

    for (int i = 0; i < SR - 1; i++) gap(1000);
    chk("R8 fresh slow run needed", pd_on, 1'b0);
    gap(1000);
    chk("R9 saturated silence counts once as slow", pd_on, 1'b1);

    for (int i = 0; i < FT - 1; i++) gap(2);
    chk("R6 not yet re-enabled", pd_on, 1'b1);
    gap(ST - 1);
    chk("R6 re-enabled again", pd_on, 1'b0);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule